// File: doc/BRIEF.md
# Serial Pin Scan Engine

This block carries up to eighty general-purpose signals across a three-wire serial link to a chain of external shift-register chips. Each scan shifts a snapshot of the per-bit output register out on a serial data line. During the same scan it collects an equal number of bits from a serial return line. A load strobe closes the scan, and the external chips use it to latch their outputs and sample their inputs.

A single control register sets the speed, the width and whether the link runs. The speed is a clock divider: the serial clock period is twice the divider plus one, in system-clock cycles. The width is a pin count given in groups of eight. The run bit starts the engine. While the engine runs, scans follow each other back to back. A new control value is taken up only where one scan ends and the next begins.

The captured bits go to a per-bit input register. That register changes only when a scan completes, so software never sees a half-updated set of inputs.

Top module: `serial_pin_link`

## Requirements
- R1: After reset the serial clock is high, the load strobe is low, the serial data output is 0, and every bit of the input register is 0.
- R2: The divider sits in control bits 31:16. Each serial clock pulse is low for exactly divider+1 system cycles and then high for exactly divider+1 system cycles.
- R3: The group count sits in control bits 9:6. A scan emits exactly 8 × group-count clock pulses. A group count above 10 is treated as 10, which gives 80 pins. A group count of 0 produces no clocking.
- R4: The run bit is control bit 0. While it is 0, no scan starts: the serial clock stays high and the load strobe stays low.
- R5: During pulse k of a scan (counting from 0), output-register bit k is on the serial data output. That output changes only on a falling serial clock edge. The output register is written one 32-bit bank at a time, and bank b holds pins 32b to 32b+31.
- R6: The value on the serial return line at the rising edge of pulse k goes to input-register bit k. The input register is updated only at the end of the scan, when the load strobe falls. Bits at or above the scan's pin count read 0.
- R7: After the last pulse, the load strobe is high for exactly 2 × (divider+1) system cycles. The serial clock is held high during that time.
- R8: While the run bit stays 1, the next scan's first falling clock edge comes in the same cycle the load strobe falls. A control write made during a scan does not change that scan. It is applied at the next scan boundary, and clearing the run bit lets the scan in progress finish.
- R9: The output bits of a scan are sampled at its first falling edge. Writes to the output register during a scan affect only later scans.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 32 | Control value: divider 31:16, group count 9:6, run bit 0 |
| outWe | input | 1 | Output register bank write strobe |
| outBank | input | 2 | Bank being written (0..2) |
| outWdata | input | 32 | Bank data; bank 2 uses the low 16 bits |
| sDin | input | 1 | Serial return line from the external chain |
| sClk | output | 1 | Serial clock, idles high |
| sLoad | output | 1 | Load strobe that closes each scan |
| sDout | output | 1 | Serial data to the external chain |
| inVal | output | 80 | Input register, one bit per pin |

## Verification
The hardest situation to reach from the ports is a control write that lands in the middle of a scan. The bench has to show that the running scan keeps its old divider and pin count, and that the next scan starts on exactly the cycle the load strobe falls, with the new settings. To get there, the stimulus enables the engine and waits for the first falling serial clock edge. It then writes a new divider and pin count, or a new output bank, while the first scan is still shifting. It clears the run bit only after it has seen the first scan end. The scoreboard then expects two scans with different widths, periods or output bits, joined back to back.

// File: rtl/serial_pin_link_pkg.sv
package serial_pin_link_pkg;

  // Control register field placement
  localparam int CTRL_W  = 32;
  localparam int DIV_LSB = 16;
  localparam int GRP_LSB = 6;
  localparam int EN_BIT  = 0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } scanStateT;

  // One-cycle strobes from the sequencer to the datapath
  typedef struct packed {
    logic snap;     // take output snapshot, clear capture buffer
    logic shift;    // advance output shifter on a falling edge
    logic capture;  // sample return line on a rising edge
    logic commit;   // move capture buffer into input register
  } strobeT;

endpackage

// File: rtl/serial_pin_link_ctrl.sv
module serial_pin_link_ctrl
  import serial_pin_link_pkg::*;
#(
  parameter int MAX_PINS = 80,
  parameter int DIV_W    = 16,
  parameter int GRP_W    = 4,
  parameter int IDX_W    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  output logic              sClk,
  output logic              sLoad,
  output strobeT            strb,
  output logic [IDX_W-1:0]  bitIdx
);

  localparam int MAX_GRP = MAX_PINS / 8;

  // Programmed control value (applied at scan boundaries)
  logic [DIV_W-1:0] cfgDiv;
  logic [GRP_W-1:0] cfgGrp;
  logic             cfgEn;

  // Settings of the scan in progress
  logic [DIV_W-1:0] actDiv;
  logic [IDX_W-1:0] actBits;

  scanStateT        state;
  logic [DIV_W-1:0] halfCnt;
  logic             phase;   // 0: low half, 1: high half

  logic [IDX_W-1:0] cfgBits;
  logic             startOk;
  logic             tick;
  logic             lastBit;
  logic             unusedCtrlBits;

  assign unusedCtrlBits = ^{ctrlWdata[DIV_LSB-1:GRP_LSB+GRP_W],
                            ctrlWdata[GRP_LSB-1:EN_BIT+1]};

  always_comb begin
    if (cfgGrp > GRP_W'(MAX_GRP)) cfgBits = IDX_W'(MAX_PINS);
    else                          cfgBits = IDX_W'(cfgGrp) << 3;
  end

  assign startOk = cfgEn && (cfgGrp != '0);
  assign tick    = (halfCnt == actDiv);
  assign lastBit = (bitIdx == actBits - IDX_W'(1));

  always_comb begin
    strb.snap    = ((state == ST_IDLE) && startOk) ||
                   ((state == ST_LOAD) && tick && phase && startOk);
    strb.capture = (state == ST_SHIFT) && tick && !phase;
    strb.shift   = (state == ST_SHIFT) && tick && phase && !lastBit;
    strb.commit  = (state == ST_LOAD) && tick && phase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgDiv <= '0;
      cfgGrp <= '0;
      cfgEn  <= 1'b0;
    end else if (ctrlWe) begin
      cfgDiv <= ctrlWdata[DIV_LSB +: DIV_W];
      cfgGrp <= ctrlWdata[GRP_LSB +: GRP_W];
      cfgEn  <= ctrlWdata[EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sClk    <= 1'b1;
      sLoad   <= 1'b0;
      halfCnt <= '0;
      phase   <= 1'b0;
      bitIdx  <= '0;
      actDiv  <= '0;
      actBits <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startOk) begin
            state   <= ST_SHIFT;
            sClk    <= 1'b0;
            halfCnt <= '0;
            phase   <= 1'b0;
            bitIdx  <= '0;
            actDiv  <= cfgDiv;
            actBits <= cfgBits;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            halfCnt <= '0;
            if (!phase) begin
              sClk  <= 1'b1;
              phase <= 1'b1;
            end else if (lastBit) begin
              state <= ST_LOAD;
              sLoad <= 1'b1;
              phase <= 1'b0;
            end else begin
              sClk   <= 1'b0;
              phase  <= 1'b0;
              bitIdx <= bitIdx + IDX_W'(1);
            end
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
        ST_LOAD: begin
          if (tick) begin
            halfCnt <= '0;
            if (!phase) begin
              phase <= 1'b1;
            end else begin
              sLoad <= 1'b0;
              phase <= 1'b0;
              if (startOk) begin
                state   <= ST_SHIFT;
                sClk    <= 1'b0;
                bitIdx  <= '0;
                actDiv  <= cfgDiv;
                actBits <= cfgBits;
              end else begin
                state <= ST_IDLE;
              end
            end
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: the half-period counter never passes the active divider
  a_r2_half_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (halfCnt <= actDiv));

  // R3: the pulse index stays inside the active pin count
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SHIFT) |-> (bitIdx < actBits));

  // R4: with the run bit clear, an idle engine stays idle with the clock high
  a_r4_no_start: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_IDLE) && !cfgEn) |=> (sClk && !sLoad));

  // R7: the clock is held high while the load strobe is asserted
  a_r7_load_clk_high: assert property (@(posedge clk) disable iff (!rstN)
    sLoad |-> sClk);

  // R8: the settings of a running scan do not change
  a_r8_hold_settings: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_SHIFT) && ($past(state) == ST_SHIFT)) |->
      ($stable(actDiv) && $stable(actBits)));

endmodule

// File: rtl/serial_pin_link_dp.sv
module serial_pin_link_dp
  import serial_pin_link_pkg::*;
#(
  parameter int MAX_PINS  = 80,
  parameter int BANK_W    = 32,
  parameter int NUM_BANKS = 3,
  parameter int BSEL_W    = 2,
  parameter int IDX_W     = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                outWe,
  input  logic [BSEL_W-1:0]   outBank,
  input  logic [BANK_W-1:0]   outWdata,
  input  strobeT              strb,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic                sDin,
  output logic                sDout,
  output logic [MAX_PINS-1:0] inVal
);

  logic [MAX_PINS-1:0] outReg;
  logic [MAX_PINS-1:0] shiftReg;
  logic [MAX_PINS-1:0] capReg;
  logic                unusedDataBits;

  // Upper bits of the last, narrower bank have no storage
  assign unusedDataBits = ^outWdata;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;
    localparam int W  = ((MAX_PINS - LO) < BANK_W) ? (MAX_PINS - LO) : BANK_W;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        outReg[LO +: W] <= '0;
      end else if (outWe && (outBank == BSEL_W'(b))) begin
        outReg[LO +: W] <= outWdata[W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.snap) begin
      shiftReg <= outReg;
    end else if (strb.shift) begin
      shiftReg <= shiftReg >> 1;
    end
  end

  assign sDout = shiftReg[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capReg <= '0;
    end else if (strb.snap) begin
      capReg <= '0;
    end else if (strb.capture) begin
      capReg[bitIdx] <= sDin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inVal <= '0;
    end else if (strb.commit) begin
      inVal <= capReg;
    end
  end

  // R6: the input register moves only after a commit strobe
  a_r6_commit_only: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inVal) |-> $past(strb.commit));

  // R9: the output shifter moves only on a snapshot or a shift strobe
  a_r9_snapshot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shiftReg) |-> ($past(strb.snap) || $past(strb.shift)));

  // strobes that change the same storage never coincide
  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.capture && (strb.snap || strb.commit || strb.shift)));

endmodule

// File: rtl/serial_pin_link.sv
module serial_pin_link
  import serial_pin_link_pkg::*;
#(
  parameter int MAX_PINS = 80,
  parameter int DIV_W    = 16,
  parameter int GRP_W    = 4,
  parameter int BANK_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWe,
  input  logic [31:0]         ctrlWdata,
  input  logic                outWe,
  input  logic [1:0]          outBank,
  input  logic [31:0]         outWdata,
  input  logic                sDin,
  output logic                sClk,
  output logic                sLoad,
  output logic                sDout,
  output logic [MAX_PINS-1:0] inVal
);

  localparam int NUM_BANKS = (MAX_PINS + BANK_W - 1) / BANK_W;
  localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int IDX_W     = $clog2(MAX_PINS + 1);

  strobeT           strb;
  logic [IDX_W-1:0] bitIdx;

  serial_pin_link_ctrl #(
    .MAX_PINS (MAX_PINS),
    .DIV_W    (DIV_W),
    .GRP_W    (GRP_W),
    .IDX_W    (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .sClk      (sClk),
    .sLoad     (sLoad),
    .strb      (strb),
    .bitIdx    (bitIdx)
  );

  serial_pin_link_dp #(
    .MAX_PINS  (MAX_PINS),
    .BANK_W    (BANK_W),
    .NUM_BANKS (NUM_BANKS),
    .BSEL_W    (BSEL_W),
    .IDX_W     (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .outWe    (outWe),
    .outBank  (outBank[BSEL_W-1:0]),
    .outWdata (outWdata[BANK_W-1:0]),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .sDin     (sDin),
    .sDout    (sDout),
    .inVal    (inVal)
  );

  // R5: serial data changes only together with a falling serial clock
  a_r5_dout_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sDout) |-> $fell(sClk));

endmodule

// File: tb/serial_pin_link_bench.sv
`timescale 1ns/1ps
module serial_pin_link_bench;

  typedef struct {
    int          nbits;
    int          div;
    logic [79:0] outv;
    logic [79:0] inv;
    bit          cont;
  } scanT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWe = 1'b0;
  logic [31:0] ctrlWdata = '0;
  logic        outWe = 1'b0;
  logic [1:0]  outBank = '0;
  logic [31:0] outWdata = '0;
  logic        sDin = 1'b0;
  logic        sClk;
  logic        sLoad;
  logic        sDout;
  logic [79:0] inVal;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  scanT        expQ[$];
  scanT        cur;
  bit          pendingValid = 0;
  int          scansEnded = 0;
  logic [79:0] outModel = '0;
  logic [79:0] extIn = '0;

  always #2.5 clk = ~clk;

  serial_pin_link u_serial_pin_link (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWe    (ctrlWe),
    .ctrlWdata (ctrlWdata),
    .outWe     (outWe),
    .outBank   (outBank),
    .outWdata  (outWdata),
    .sDin      (sDin),
    .sClk      (sClk),
    .sLoad     (sLoad),
    .sDout     (sDout),
    .inVal     (inVal)
  );

  task automatic chk(input bit ok, input string tag, input logic [79:0] act,
                     input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [79:0] maskOf(input int n);
    logic [79:0] one = 80'd1;
    return (one << n) - 80'd1;
  endfunction

  task automatic wrCtrl(input int div, input int grp, input bit en);
    @(negedge clk);
    ctrlWe    = 1'b1;
    ctrlWdata = {div[15:0], 6'b0, grp[3:0], 5'b0, en};
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrOut(input int bank, input logic [31:0] data);
    @(negedge clk);
    outWe    = 1'b1;
    outBank  = bank[1:0];
    outWdata = data;
    if (bank == 2) outModel[64 +: 16] = data[15:0];
    else           outModel[bank*32 +: 32] = data;
    @(negedge clk);
    outWe = 1'b0;
  endtask

  // driver side of the scoreboard: one expected item per scan
  task automatic pushScan(input int nbits, input int div, input bit cont);
    scanT it;
    it.nbits = nbits;
    it.div   = div;
    it.outv  = outModel & maskOf(nbits);
    it.inv   = extIn & maskOf(nbits);
    it.cont  = cont;
    expQ.push_back(it);
  endtask

  task automatic waitFall();
    do @(negedge clk); while (sClk !== 1'b0);
  endtask

  task automatic waitEnded(input int target);
    do @(negedge clk); while (scansEnded < target);
  endtask

  task automatic waitDone();
    do @(negedge clk); while (expQ.size() != 0 || pendingValid);
  endtask

  task automatic idleWindow(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sClk !== 1'b1 || sLoad !== 1'b0) bad++;
    end
    chk(bad == 0, tag, 80'(bad), 80'd0);
  endtask

  // monitor side of the scoreboard
  initial begin
    logic        prevClk = 1'b1;
    logic        prevLoad = 1'b0;
    int          lvlCnt = 1;
    int          riseCnt = 0;
    int          loadCnt = 0;
    logic [79:0] obsOut = '0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        prevClk = 1'b1; prevLoad = 1'b0; lvlCnt = 1; riseCnt = 0; obsOut = '0;
      end else begin
        if (sClk !== prevClk) begin
          if (sClk === 1'b1) begin
            if (expQ.size() > 0)
              chk(lvlCnt == expQ[0].div + 1, "R2 low half length",
                  80'(lvlCnt), 80'(expQ[0].div + 1));
            if (riseCnt < 80) obsOut[riseCnt] = sDout;
            riseCnt++;
          end else if (!prevLoad && riseCnt > 0 && expQ.size() > 0) begin
            chk(lvlCnt == expQ[0].div + 1, "R2 high half length",
                80'(lvlCnt), 80'(expQ[0].div + 1));
          end
          lvlCnt = 1;
        end else begin
          lvlCnt++;
        end
        if (sLoad === 1'b1 && prevLoad === 1'b0) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R4 unexpected scan", 80'd1, 80'd0);
          end else begin
            cur = expQ.pop_front();
            pendingValid = 1;
            chk(riseCnt == cur.nbits, "R3 pulse count", 80'(riseCnt), 80'(cur.nbits));
            chk((obsOut & maskOf(cur.nbits)) == cur.outv, "R5/R9 output bits",
                obsOut & maskOf(cur.nbits), cur.outv);
            chk(sClk === 1'b1, "R7 clock high at load", 80'(sClk), 80'd1);
          end
          loadCnt = 0;
        end
        if (sLoad === 1'b1) loadCnt++;
        if (sLoad === 1'b0 && prevLoad === 1'b1) begin
          if (pendingValid) begin
            chk(loadCnt == 2 * (cur.div + 1), "R7 load length",
                80'(loadCnt), 80'(2 * (cur.div + 1)));
            chk(inVal == cur.inv, "R6 input register", inVal, cur.inv);
            chk(sClk === (cur.cont ? 1'b0 : 1'b1), "R8 boundary clock",
                80'(sClk), cur.cont ? 80'd0 : 80'd1);
          end
          pendingValid = 0;
          scansEnded++;
          riseCnt = 0;
          obsOut = '0;
        end
        prevClk  = sClk;
        prevLoad = sLoad;
      end
      sDin = (riseCnt < 80) ? extIn[riseCnt] : 1'b0;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sClk === 1'b1, "R1 clock idle", 80'(sClk), 80'd1);
    chk(sLoad === 1'b0, "R1 load low", 80'(sLoad), 80'd0);
    chk(sDout === 1'b0, "R1 data low", 80'(sDout), 80'd0);
    chk(inVal === 80'd0, "R1 input register", inVal, 80'd0);

    // R3 clamp: group count 15 runs 80 pins at divider 0
    wrOut(0, 32'hDEADBEEF);
    wrOut(1, 32'h0F1E2D3C);
    wrOut(2, 32'h00009A5C);
    extIn = 80'hC3A5_1234_5678_9ABC_DEF0;
    pushScan(80, 0, 0);
    wrCtrl(0, 15, 1);
    waitFall();
    wrCtrl(0, 15, 0);
    waitDone();

    // R6 short scan clears the upper input bits; R4 idle afterwards
    wrOut(0, 32'h000000A5);
    extIn = 80'h5A;
    pushScan(8, 1, 0);
    wrCtrl(1, 1, 1);
    waitFall();
    wrCtrl(1, 1, 0);
    waitDone();
    chk(inVal == 80'h5A, "R6 upper bits cleared", inVal, 80'h5A);
    idleWindow(60, "R4 idle after disable");

    // R9 output write during a scan goes to the next scan
    wrOut(0, 32'h00C37E19);
    extIn = 80'h9E_3C71;
    pushScan(24, 3, 1);
    wrCtrl(3, 3, 1);
    waitFall();
    base = scansEnded;
    wrOut(0, 32'h005AF00F);
    pushScan(24, 3, 0);
    waitEnded(base + 1);
    wrCtrl(3, 3, 0);
    waitDone();

    // R8 control change mid-scan applies at the boundary
    extIn = 80'hBEEF;
    pushScan(8, 0, 1);
    wrCtrl(0, 1, 1);
    waitFall();
    base = scansEnded;
    wrCtrl(2, 2, 1);
    pushScan(16, 2, 0);
    waitEnded(base + 1);
    wrCtrl(2, 2, 0);
    waitDone();

    // R3 zero groups, R4 run bit clear
    wrCtrl(5, 0, 1);
    idleWindow(100, "R3 zero group count");
    wrCtrl(5, 2, 0);
    idleWindow(100, "R4 run bit clear");
    chk(inVal == 80'hBEEF, "R6 input register held while idle", inVal, 80'hBEEF);
    chk(expQ.size() == 0, "R8 all scans seen", 80'(expQ.size()), 80'd0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule